// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache with Wrapped Line Fill

This block is a small set-associative data cache. It sits between a processor load/prefetch port and a word-wide memory read bus. Each set holds a valid bit, a dirty bit, a tag and a 16-byte line (four 32-bit words) per way. Replacement uses true least-recently-used ordering, kept as a small age counter per way. A hit is served from the line arrays. A miss picks a victim way and refills the whole line from memory. The refill begins at the word that missed and wraps around inside the line. The missed word is forwarded to the processor on the beat that brings it in.

Three request kinds are accepted. A read returns a word. A prefetch warms the cache and returns nothing. A store writes one word into the cache and marks the line dirty. The store path exists only so that lines can become dirty. When the victim of a miss is dirty, its whole line and address are pushed to an external write-back buffer in a one-cycle slot before the first refill beat is requested. Addresses are word addresses: bits [1:0] select the word in the line, the next bits select the set, and the rest form the tag.

Top module: `opc_cache`

## Requirements
- R1: A read that hits raises `rsp_valid_o` for exactly the cycle after acceptance, with the addressed word on `rsp_data_o`. It issues no memory request and `busy_o` stays low.
- R2: Every hit (read, prefetch or store) makes the hit way the most recently used in its set.
- R3: A request is accepted only while `busy_o` is low. A miss raises `busy_o` from the cycle after acceptance until the cycle after the last refill beat. Requests presented while busy are ignored.
- R4: A refill makes four beats to the same line. The word field starts at the missed word and increments modulo 4; for example, missed word 1 refills in the order 1, 2, 3, 0. `mem_addr_o` is held stable while `mem_ready_i` is low.
- R5: On a read miss, the word from the first beat appears on `rsp_data_o`, with `rsp_valid_o` high, in the cycle after that beat's handshake. It is also written into the line.
- R6: After the fourth beat the refilled line is valid, clean and most recently used, and later reads of it hit.
- R7: The victim is the lowest-numbered invalid way in the set. If every way is valid, the victim is the least recently used way.
- R8: If the victim is valid and dirty, `wb_valid_o` is high for one cycle before the first refill request. In that cycle `wb_addr_o` holds the victim's line address with word field 0, and `wb_data_o` holds word k at bits [32k+31:32k].
- R9: A prefetch that hits returns no response and changes only the replacement order.
- R10: A prefetch that misses refills and handles the victim exactly like a read miss, but returns no response.
- R11: Request kind encoding is `req_op_i` 0 = read, 1 = prefetch, 2 = store, 3 = read. A store hit writes the word and sets dirty without a response. A store miss refills the line, then writes the word and leaves the line dirty.
- R12: After reset all lines are invalid, and `busy_o`, `rsp_valid_o`, `mem_valid_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Request kind (read, prefetch, store) |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_wdata_i | input | 32 | Store data |
| busy_o | output | 1 | Miss in progress, requests not accepted |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 32 | Read data |
| mem_valid_o | output | 1 | Refill beat request |
| mem_addr_o | output | ADDR_W | Word address of the refill beat |
| mem_ready_i | input | 1 | Memory returns the beat this cycle |
| mem_rdata_i | input | 32 | Refill word, valid with `mem_ready_i` |
| wb_valid_o | output | 1 | Dirty victim push to the write-back buffer |
| wb_addr_o | output | ADDR_W | Word address of the victim line |
| wb_data_o | output | 128 | Victim line contents |

## Verification
The bench sweeps every starting word under three memory-ready patterns. A design that does not wrap, or that always starts at word 0, emits the wrong address sequence. A design that forwards the wrong beat returns a neighbouring word. Directed and pseudo-random traffic puts more than four tags through each set, mixing prefetch hits and stores. A wrong age update, or a victim rule that ignores invalid ways, then shows up as a hit where a miss was expected, or the reverse. Dirty lines are forced out to confirm that the write-back slot comes before the first refill beat and carries the stored word. Requests are also presented during refills, and a design that accepted them would corrupt the line contents the bench later reads.

// File: rtl/opc_cache_pkg.sv
package opc_cache_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int OFF_W      = 2;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PREF  = 2'd1,
    OP_STORE = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } state_e;
endpackage

// File: rtl/opc_tag_match.sv
module opc_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/opc_lru.sv
module opc_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             upd_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic [WAY_W-1:0] upd_way_i
);
  // age 0 = most recent, WAYS-1 = least recent; ages form a permutation per set
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] old_age;

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[rd_set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
      end
    end
  end

  assign old_age = age_q[upd_set_i][upd_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (upd_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way_i)          age_q[upd_set_i][w] <= '0;
        else if (age_q[upd_set_i][w] < old_age) age_q[upd_set_i][w] <= age_q[upd_set_i][w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/opc_cache.sv
module opc_cache
  import opc_cache_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W - OFF_W,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o
);
  logic [WAYS-1:0]                              valid_q [SETS];
  logic [WAYS-1:0]                              dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]                   tag_q   [SETS];
  logic [LINE_WORDS-1:0][WORD_W-1:0]            data_q  [SETS][WAYS];

  state_e            state_q;
  op_e               op_q;
  logic [TAG_W-1:0]  tag_lat_q;
  logic [SET_W-1:0]  set_q;
  logic [OFF_W-1:0]  word_q, cnt_q;
  logic [WAY_W-1:0]  vict_q;
  logic [WORD_W-1:0] wdata_q;

  logic [TAG_W-1:0]  req_tag;
  logic [SET_W-1:0]  req_set;
  logic [OFF_W-1:0]  req_word, fill_word;
  logic              hit, accept, beat, last_beat;
  logic [WAY_W-1:0]  hit_way, victim;
  logic              upd;
  logic [SET_W-1:0]  upd_set;
  logic [WAY_W-1:0]  upd_way;
  op_e               req_op;

  assign req_tag  = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_set  = req_addr_i[OFF_W +: SET_W];
  assign req_word = req_addr_i[OFF_W-1:0];
  assign req_op   = op_e'(req_op_i);

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign beat      = (state_q == ST_FILL) && mem_ready_i;
  assign last_beat = beat && (cnt_q == OFF_W'(LINE_WORDS - 1));
  assign fill_word = word_q + cnt_q;

  opc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i (valid_q[req_set]),
    .tags_i  (tag_q[req_set]),
    .tag_i   (req_tag),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  assign upd     = (accept && hit) || last_beat;
  assign upd_set = accept ? req_set : set_q;
  assign upd_way = accept ? hit_way : vict_q;

  opc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_set_i  (req_set),
    .valid_i   (valid_q[req_set]),
    .victim_o  (victim),
    .upd_i     (upd),
    .upd_set_i (upd_set),
    .upd_way_i (upd_way)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_valid_o = (state_q == ST_FILL);
  assign mem_addr_o  = {tag_lat_q, set_q, fill_word};
  assign wb_valid_o  = (state_q == ST_WB);
  assign wb_addr_o   = {tag_q[set_q][vict_q], set_q, OFF_W'(0)};
  assign wb_data_o   = data_q[set_q][vict_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_READ;
      tag_lat_q   <= '0;
      set_q       <= '0;
      word_q      <= '0;
      cnt_q       <= '0;
      vict_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (hit) begin
            if (req_op == OP_STORE) begin
              dirty_q[req_set][hit_way] <= 1'b1;
            end else if (req_op != OP_PREF) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= data_q[req_set][hit_way][req_word];
            end
          end else begin
            op_q      <= req_op;
            tag_lat_q <= req_tag;
            set_q     <= req_set;
            word_q    <= req_word;
            wdata_q   <= req_wdata_i;
            vict_q    <= victim;
            cnt_q     <= '0;
            state_q   <= (valid_q[req_set][victim] && dirty_q[req_set][victim]) ? ST_WB : ST_FILL;
          end
        end
        ST_WB: state_q <= ST_FILL;
        ST_FILL: if (beat) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0 && op_q != OP_PREF && op_q != OP_STORE) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= mem_rdata_i;
          end
          if (last_beat) begin
            valid_q[set_q][vict_q] <= 1'b1;
            dirty_q[set_q][vict_q] <= (op_q == OP_STORE);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage, no reset needed: guarded by valid bits
  always_ff @(posedge clk_i) begin
    if (accept && hit && req_op == OP_STORE)
      data_q[req_set][hit_way][req_word] <= req_wdata_i;
    if (beat)
      data_q[set_q][vict_q][fill_word] <= mem_rdata_i;
    if (last_beat) begin
      tag_q[set_q][vict_q] <= tag_lat_q;
      if (op_q == OP_STORE) data_q[set_q][vict_q][word_q] <= wdata_q;
    end
  end
endmodule

// File: rtl/opc_cache_chk.sv
module opc_cache_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wb_valid_o
);
  // R3
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));

  // R3
  fill_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o || wb_valid_o) |-> busy_o);

  // R8
  wb_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o && mem_valid_o);

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o));

  // R4
  wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> !mem_valid_o ||
      ((mem_addr_o[1:0] == 2'($past(mem_addr_o[1:0]) + 2'd1)) &&
       (mem_addr_o[ADDR_W-1:2] == $past(mem_addr_o[ADDR_W-1:2]))));

  // R6
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_valid_o && mem_ready_i));
endmodule

bind opc_cache opc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .wb_valid_o  (wb_valid_o)
);

// File: tb/opc_cache_tb.sv
`timescale 1ns/1ps
module opc_cache_tb;
  localparam int AW = 14;
  localparam int NW = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy, rsp_valid, mem_valid, mem_ready = 1'b0, wb_valid;
  logic [31:0] rsp_data, mem_rdata;
  logic [AW-1:0] mem_addr, wb_addr;
  logic [127:0] wb_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_fn(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hC3A5_0000;
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  opc_cache #(.ADDR_W(AW), .WAYS(NW), .SETS(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  // reference state
  bit          m_valid [NS][NW];
  bit          m_dirty [NS][NW];
  int          m_tag   [NS][NW];
  logic [31:0] m_data  [NS][NW][4];
  int          m_age   [NS][NW];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic touch(input int s, input int w);
    int old;
    old = m_age[s][w];
    for (int v = 0; v < NW; v++) begin
      if (v == w) m_age[s][v] = 0;
      else if (m_age[s][v] < old) m_age[s][v]++;
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [AW-1:0] addr,
                        input logic [31:0] wd, input int mode, input bit poke);
    int s, t, wd_i, hw, vw, cyc, beats, wbs, last_hs_idx;
    bit hit, is_rd, exp_wb, hs;
    s = int'(addr[3:2]);
    t = int'(addr[AW-1:4]);
    wd_i = int'(addr[1:0]);
    is_rd = (op == 2'd0) || (op == 2'd3);
    hit = 1'b0; hw = 0;
    for (int w = 0; w < NW; w++)
      if (m_valid[s][w] && m_tag[s][w] == t && !hit) begin hit = 1'b1; hw = w; end

    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // R2 R6 R7: hit/miss prediction follows the replacement order
    chk(busy == !hit, "R2 R6 R7 hit-or-miss", busy, !hit);
    if (hit) begin
      chk(!mem_valid, "R1 no memory on hit", mem_valid, 0);
      if (is_rd) chk(rsp_valid && rsp_data == m_data[s][hw][wd_i], "R1 hit data",
                     {rsp_valid, rsp_data}, {1'b1, m_data[s][hw][wd_i]});
      else if (op == 2'd1) chk(!rsp_valid, "R9 prefetch hit silent", rsp_valid, 0);
      else chk(!rsp_valid, "R11 store hit silent", rsp_valid, 0);
      if (op == 2'd2) begin m_data[s][hw][wd_i] = wd; m_dirty[s][hw] = 1'b1; end
      touch(s, hw);
      return;
    end

    vw = -1;
    for (int w = 0; w < NW; w++) if (!m_valid[s][w] && vw < 0) vw = w;
    if (vw < 0) for (int w = 0; w < NW; w++) if (m_age[s][w] == NW - 1) vw = w;
    exp_wb = m_valid[s][vw] && m_dirty[s][vw];
    cyc = 0; beats = 0; wbs = 0; last_hs_idx = -1;
    while (busy && cyc < 200) begin
      if (last_hs_idx == 0) begin
        if (is_rd) chk(rsp_valid && rsp_data == mem_fn(addr), "R5 forwarded word",
                       {rsp_valid, rsp_data}, {1'b1, mem_fn(addr)});
        else chk(!rsp_valid, "R10 R11 no response on fill", rsp_valid, 0);
      end else begin
        chk(!rsp_valid, "R5 single response", rsp_valid, 0);
      end
      if (wb_valid) begin
        wbs++;
        chk(exp_wb && beats == 0 && !mem_valid, "R8 write-back slot",
            {exp_wb, beats[3:0], mem_valid}, {1'b1, 4'd0, 1'b0});
        chk(wb_addr == AW'({m_tag[s][vw], 2'(s), 2'd0}), "R8 victim address",
            wb_addr, AW'({m_tag[s][vw], 2'(s), 2'd0}));
        chk(wb_data == {m_data[s][vw][3], m_data[s][vw][2], m_data[s][vw][1], m_data[s][vw][0]},
            "R8 victim data", wb_data,
            {m_data[s][vw][3], m_data[s][vw][2], m_data[s][vw][1], m_data[s][vw][0]});
      end
      if (mem_valid) begin
        logic [AW-1:0] ea;
        ea = {addr[AW-1:2], 2'(addr[1:0] + 2'(beats))};
        chk(mem_addr == ea, "R4 wrapped order", mem_addr, ea);
      end
      case (mode)
        0: mem_ready = 1'b1;
        1: mem_ready = cyc[0];
        default: mem_ready = (cyc % 3 == 2);
      endcase
      // R3: traffic while busy must be ignored
      req_valid = poke && beats < 2;
      req_op = 2'd2; req_addr = addr ^ 14'h3F0; req_wdata = 32'hDEAD_BEEF;
      hs = mem_valid && mem_ready;
      @(posedge clk);
      @(negedge clk);
      last_hs_idx = hs ? beats : -1;
      if (hs) beats++;
      cyc++;
    end
    mem_ready = 1'b0;
    req_valid = 1'b0;
    chk(beats == 4, "R4 four beats", beats, 4);
    chk(wbs == int'(exp_wb), "R8 write-back count", wbs, exp_wb);
    chk(!busy && !mem_valid, "R3 busy ends after fill", {busy, mem_valid}, 0);
    for (int k = 0; k < 4; k++) m_data[s][vw][k] = mem_fn({addr[AW-1:2], 2'(k)});
    m_valid[s][vw] = 1'b1;
    m_dirty[s][vw] = (op == 2'd2);
    m_tag[s][vw] = t;
    if (op == 2'd2) m_data[s][vw][wd_i] = wd;
    touch(s, vw);
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int s, input int w);
    return AW'({10'(t), 2'(s), 2'(w)});
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; m_age[s][w] = w;
        for (int k = 0; k < 4; k++) m_data[s][w][k] = '0;
      end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !rsp_valid && !mem_valid && !wb_valid, "R12 reset outputs",
        {busy, rsp_valid, mem_valid, wb_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_valid && !wb_valid, "R12 idle after reset",
        {busy, rsp_valid, mem_valid, wb_valid}, 0);

    // R4 R5: every starting word under every ready pattern
    for (int m = 0; m < 3; m++)
      for (int w = 0; w < 4; w++) access(2'd0, mk(1 + m * 4 + w, w, w), 0, m, 1'b0);
    // R1: read back whole lines, op 3 decodes as read
    for (int w = 0; w < 4; w++) access(2'(w == 3 ? 3 : 0), mk(9, 0, w), 0, 0, 1'b0);
    // R7 R2: fill set 1 then evict with a touched way
    for (int t = 20; t < 24; t++) access(2'd0, mk(t, 1, 0), 0, 0, 1'b0);
    access(2'd1, mk(20, 1, 2), 0, 0, 1'b0);        // R9 prefetch hit makes way MRU
    access(2'd0, mk(24, 1, 1), 0, 1, 1'b0);
    access(2'd0, mk(20, 1, 3), 0, 0, 1'b0);
    access(2'd0, mk(21, 1, 3), 0, 0, 1'b0);
    // R11 R8: dirty lines forced out
    access(2'd2, mk(30, 2, 1), 32'h1111_2222, 0, 1'b0);
    access(2'd2, mk(30, 2, 3), 32'h3333_4444, 0, 1'b0);
    for (int t = 31; t < 35; t++) access(2'd0, mk(t, 2, 2), 0, 2, 1'b0);
    // R10 prefetch miss, R3 pokes during fill
    access(2'd1, mk(40, 3, 2), 0, 1, 1'b1);
    access(2'd0, mk(40, 3, 2), 0, 0, 1'b0);
    access(2'd0, mk(40, 3, 2) ^ 14'h3F0, 0, 0, 1'b1);

    seed = 32'h1234_5678;
    for (int i = 0; i < 500; i++) begin
      int r, op;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'h7FFF_FFFF;
      op = (r % 4 == 3) ? 2 : ((r % 4 == 2) ? 1 : 0);
      access(2'(op), mk((r >> 4) % 6, (r >> 8) % 4, (r >> 10) % 4), 32'(r * 7), (r >> 12) % 3,
             ((r >> 14) % 4) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule